// File: doc/BRIEF.md
# Peripheral Clock Gate Controller

This block derives one clock enable, and one gated clock, for each peripheral on a shared peripheral clock. Peripherals fall into two groups. The automatic group follows each peripheral's own enable input, so a peripheral that is switched off also loses its clock. The manual group has no such input: each of its peripherals is stopped by a dedicated bit in a control register. One master bit in the same register stops every peripheral clock at once.

A bus access to a peripheral always gets a clock, whatever the gate setting. While a peripheral's access strobe is high, its enable is forced on. A small per-peripheral state machine then keeps the enable on for two more cycles. After that the programmed setting applies again. Each enable passes through a latch that is open only while the clock is low. A change of enable therefore never cuts a high phase short.

Software sees two registers on a simple read/write port. Address 0 is the control register and can be written and read back. Address 1 is a read-only status register showing the effective enable of every peripheral.

Top module: `periph_clk_gate`

Override state machine (one per peripheral). States: OVR_IDLE (no override), OVR_HOLD1 (first cycle after an access), OVR_HOLD2 (second cycle after an access). Transitions:
- OVR_IDLE to OVR_HOLD1 on access.
- OVR_HOLD1 to OVR_HOLD2 without access.
- OVR_HOLD2 to OVR_IDLE without access.
- OVR_HOLD1 or OVR_HOLD2 back to OVR_HOLD1 on a fresh access.
- OVR_IDLE stays in OVR_IDLE without access.

## Requirements
- R1: Peripheral i with i below N_AUTO has `clk_en_o[i]` equal to `periph_en_i[i]` when the master bit is clear and no override is active.
- R2: Peripheral N_AUTO+j has its clock on when control bit j is 0 and off when it is 1, provided the master bit is clear and no override is active.
- R3: When control bit DW-1 (the master off bit) is 1, every enable is 0 unless that peripheral has an active override.
- R4: In any cycle where `access_i[i]` is high, `clk_en_o[i]` is 1, regardless of control bits and enable inputs.
- R5: The override lasts for the access cycle plus the two following cycles. A new access during those cycles restarts the two-cycle tail. After the tail, the programmed setting returns.
- R6: `clk_en_o` changes only while `clk_i` is low. An input change during the high phase appears only after the falling edge.
- R7: After reset, the control register is 0, so all manual clocks run and the master bit is clear. `rd_data_o` is 0.
- R8: A read with `rd_en_i` returns data on `rd_data_o` one cycle later. Address 0 returns the control register (bits N_MAN-1:0 manual off, bit DW-1 master). Address 1 returns the effective enable vector of the access cycle in bits NP-1:0. Any other address returns 0.
- R9: A write to any address other than 0 changes no state. The control register and the enables stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Write address |
| wr_data_i | input | DW | Write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | AW | Read address |
| rd_data_o | output | DW | Read data, one cycle after the strobe |
| periph_en_i | input | N_AUTO | Enable bits of automatically gated peripherals |
| access_i | input | N_AUTO+N_MAN | Per-peripheral bus access strobes |
| clk_en_o | output | N_AUTO+N_MAN | Glitch-free clock enables |
| gclk_o | output | N_AUTO+N_MAN | Gated clocks |

## Verification
Alternating enable patterns on the automatic group separate per-bit following from stuck or swapped bits. Mixed manual-off patterns check the polarity and position of each control bit. Single, back-to-back and spaced accesses are applied while the master bit is set and while manual gates are closed. These show the exact length of the override tail and its restart, as distinct from a plain gate setting. An enable input flipped during the high phase, a write to the status address and a read of an unused address confirm the latch timing and that those inputs leave the state untouched.

// File: rtl/pcg_pkg.sv
`timescale 1ns/1ps
package pcg_pkg;
    typedef enum logic [1:0] {
        OVR_IDLE  = 2'd0,
        OVR_HOLD1 = 2'd1,
        OVR_HOLD2 = 2'd2
    } ovr_state_t;

    localparam int ADDR_CTRL = 0;
    localparam int ADDR_STAT = 1;
endpackage

// File: rtl/pcg_regs.sv
`timescale 1ns/1ps
module pcg_regs #(
    parameter int DW    = 32,
    parameter int AW    = 2,
    parameter int N_MAN = 3,
    parameter int NP    = 7
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [AW-1:0]    wr_addr_i,
    input  logic [DW-1:0]    wr_data_i,
    input  logic             rd_en_i,
    input  logic [AW-1:0]    rd_addr_i,
    input  logic [NP-1:0]    eff_en_i,
    output logic [N_MAN-1:0] man_off_o,
    output logic             master_off_o,
    output logic [DW-1:0]    rd_data_o
);
    import pcg_pkg::*;

    localparam int MASTER_BIT = DW - 1;

    logic [N_MAN-1:0] man_off_q;
    logic             master_q;
    logic [DW-1:0]    ctrl_word;
    logic [DW-1:0]    stat_word;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            man_off_q <= '0;
            master_q  <= 1'b0;
        end else if (wr_en_i && (int'(wr_addr_i) == ADDR_CTRL)) begin
            man_off_q <= wr_data_i[N_MAN-1:0];
            master_q  <= wr_data_i[MASTER_BIT];
        end
    end

    always_comb begin
        ctrl_word              = '0;
        ctrl_word[N_MAN-1:0]   = man_off_q;
        ctrl_word[MASTER_BIT]  = master_q;
        stat_word              = '0;
        stat_word[NP-1:0]      = eff_en_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rd_data_o <= '0;
        end else if (rd_en_i) begin
            if (int'(rd_addr_i) == ADDR_CTRL)      rd_data_o <= ctrl_word;
            else if (int'(rd_addr_i) == ADDR_STAT) rd_data_o <= stat_word;
            else                                   rd_data_o <= '0;
        end
    end

    assign man_off_o    = man_off_q;
    assign master_off_o = master_q;
endmodule

// File: rtl/pcg_override.sv
`timescale 1ns/1ps
module pcg_override (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic access_i,
    output logic hold_o
);
    import pcg_pkg::*;

    ovr_state_t state_q, state_d;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= OVR_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OVR_IDLE:  state_d = access_i ? OVR_HOLD1 : OVR_IDLE;
            OVR_HOLD1: state_d = access_i ? OVR_HOLD1 : OVR_HOLD2;
            OVR_HOLD2: state_d = access_i ? OVR_HOLD1 : OVR_IDLE;
            default:   state_d = OVR_IDLE;
        endcase
    end

    always_comb begin
        hold_o = access_i || (state_q != OVR_IDLE);
    end
endmodule

// File: rtl/pcg_gate_cell.sv
`timescale 1ns/1ps
module pcg_gate_cell (
    input  logic clk_i,
    input  logic req_i,
    output logic en_o,
    output logic gclk_o
);
    logic en_q;

    always_latch begin
        if (!clk_i) en_q = req_i;
    end

    assign en_o   = en_q;
    assign gclk_o = clk_i & en_q;
endmodule

// File: rtl/periph_clk_gate.sv
`timescale 1ns/1ps
module periph_clk_gate #(
    parameter int N_AUTO = 4,
    parameter int N_MAN  = 3,
    parameter int DW     = 32,
    parameter int AW     = 2
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    wr_en_i,
    input  logic [AW-1:0]           wr_addr_i,
    input  logic [DW-1:0]           wr_data_i,
    input  logic                    rd_en_i,
    input  logic [AW-1:0]           rd_addr_i,
    output logic [DW-1:0]           rd_data_o,
    input  logic [N_AUTO-1:0]       periph_en_i,
    input  logic [N_AUTO+N_MAN-1:0] access_i,
    output logic [N_AUTO+N_MAN-1:0] clk_en_o,
    output logic [N_AUTO+N_MAN-1:0] gclk_o
);
    localparam int NP = N_AUTO + N_MAN;

    logic [N_MAN-1:0] man_off;
    logic             master_off;
    logic [NP-1:0]    base_en;
    logic [NP-1:0]    hold;
    logic [NP-1:0]    req;

    pcg_regs #(.DW(DW), .AW(AW), .N_MAN(N_MAN), .NP(NP)) u_regs (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .wr_en_i      (wr_en_i),
        .wr_addr_i    (wr_addr_i),
        .wr_data_i    (wr_data_i),
        .rd_en_i      (rd_en_i),
        .rd_addr_i    (rd_addr_i),
        .eff_en_i     (req),
        .man_off_o    (man_off),
        .master_off_o (master_off),
        .rd_data_o    (rd_data_o)
    );

    for (genvar a = 0; a < N_AUTO; a++) begin : g_auto
        assign base_en[a] = periph_en_i[a];
    end

    for (genvar m = 0; m < N_MAN; m++) begin : g_man
        assign base_en[N_AUTO+m] = ~man_off[m];
    end

    assign req = hold | (base_en & {NP{~master_off}});

    for (genvar p = 0; p < NP; p++) begin : g_periph
        pcg_override u_ovr (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .access_i (access_i[p]),
            .hold_o   (hold[p])
        );
        pcg_gate_cell u_cell (
            .clk_i  (clk_i),
            .req_i  (req[p]),
            .en_o   (clk_en_o[p]),
            .gclk_o (gclk_o[p])
        );
    end
endmodule

// File: rtl/pcg_checker.sv
`timescale 1ns/1ps
module pcg_checker #(
    parameter int N_AUTO = 4,
    parameter int N_MAN  = 3
) (
    input logic                    clk_i,
    input logic                    rst_ni,
    input logic [N_AUTO-1:0]       periph_en_i,
    input logic [N_AUTO+N_MAN-1:0] access_i,
    input logic [N_AUTO+N_MAN-1:0] clk_en_o,
    input logic [N_MAN-1:0]        man_off,
    input logic                    master_off
);
    localparam int NP = N_AUTO + N_MAN;

    logic [NP-1:0] acc_d1, acc_d2;
    logic [1:0]    cyc;
    logic          quiet;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            acc_d1 <= '0;
            acc_d2 <= '0;
            cyc    <= '0;
        end else begin
            acc_d1 <= access_i;
            acc_d2 <= acc_d1;
            if (cyc != 2'd3) cyc <= cyc + 2'd1;
        end
    end

    assign quiet = (access_i == '0) && (acc_d1 == '0) && (acc_d2 == '0);

    // R4: an access always gets its clock
    p_access_on_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (access_i & ~clk_en_o) == '0);

    // R5: two-cycle tail after an access
    p_tail_on_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cyc >= 2'd1) |-> (((acc_d1 | acc_d2) & ~clk_en_o) == '0));

    // R1: automatic group follows enables
    p_auto_follow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (quiet && !master_off) |-> (clk_en_o[N_AUTO-1:0] == periph_en_i));

    // R2: manual group follows control bits
    p_manual_bits_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (quiet && !master_off) |-> (clk_en_o[NP-1:N_AUTO] == ~man_off));

    // R3: master off stops everything
    p_master_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (quiet && master_off) |-> (clk_en_o == '0));
endmodule

bind periph_clk_gate pcg_checker #(.N_AUTO(N_AUTO), .N_MAN(N_MAN)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .periph_en_i (periph_en_i),
    .access_i    (access_i),
    .clk_en_o    (clk_en_o),
    .man_off     (man_off),
    .master_off  (master_off)
);

// File: tb/periph_clk_gate_tb.sv
`timescale 1ns/1ps
module periph_clk_gate_tb;
    localparam int N_AUTO = 4;
    localparam int N_MAN  = 3;
    localparam int NP     = N_AUTO + N_MAN;
    localparam int DW     = 32;
    localparam int AW     = 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              wr_en, rd_en;
    logic [AW-1:0]     wr_addr, rd_addr;
    logic [DW-1:0]     wr_data, rd_data;
    logic [N_AUTO-1:0] pen;
    logic [NP-1:0]     acc, en, gclk;

    always #2 clk = ~clk;

    periph_clk_gate #(.N_AUTO(N_AUTO), .N_MAN(N_MAN), .DW(DW), .AW(AW)) u_dut (
        .clk_i(clk), .rst_ni(rst_n),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .periph_en_i(pen), .access_i(acc), .clk_en_o(en), .gclk_o(gclk)
    );

    typedef struct {
        logic [NP-1:0] en_exp;
        bit            rd_chk;
        logic [DW-1:0] rd_exp;
        string         tag;
    } item_t;

    item_t         sb_q[$];
    int            vecs = 0;
    int            errs = 0;
    bit            done = 0;
    logic [N_MAN-1:0] m_man = '0;
    bit            m_master = 0;
    int            tail[NP];
    bit            rd_pend = 0;
    logic [DW-1:0] rd_pend_val = '0;

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [NP-1:0] model_en(input logic [N_AUTO-1:0] p, input logic [NP-1:0] a);
        logic [NP-1:0] r;
        for (int i = 0; i < NP; i++) begin
            logic b;
            b = (i < N_AUTO) ? p[i] : ~m_man[i-N_AUTO];
            r[i] = a[i] || (tail[i] > 0) || (!m_master && b);
        end
        return r;
    endfunction

    task automatic cyc(input logic [N_AUTO-1:0] p, input logic [NP-1:0] a,
                       input bit we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                       input bit re, input logic [AW-1:0] ra, input string tag);
        item_t it;
        logic [DW-1:0] cw;
        @(negedge clk);
        pen = p; acc = a; wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
        it.en_exp = model_en(p, a);
        it.rd_chk = rd_pend;
        it.rd_exp = rd_pend_val;
        it.tag    = tag;
        sb_q.push_back(it);
        cw = '0; cw[N_MAN-1:0] = m_man; cw[DW-1] = m_master;
        rd_pend = re;
        if (ra == 2'd0)      rd_pend_val = cw;
        else if (ra == 2'd1) rd_pend_val = {{(DW-NP){1'b0}}, it.en_exp};
        else                 rd_pend_val = '0;
        if (we && wa == 2'd0) begin
            m_man = wd[N_MAN-1:0];
            m_master = wd[DW-1];
        end
        for (int i = 0; i < NP; i++) begin
            if (a[i]) tail[i] = 2;
            else if (tail[i] > 0) tail[i] = tail[i] - 1;
        end
    endtask

    task automatic idle(input logic [N_AUTO-1:0] p, input string tag);
        cyc(p, '0, 0, '0, '0, 0, '0, tag);
    endtask

    task automatic wr(input logic [N_AUTO-1:0] p, input logic [AW-1:0] wa, input logic [DW-1:0] wd, input string tag);
        cyc(p, '0, 1, wa, wd, 0, '0, tag);
    endtask

    task automatic rd(input logic [N_AUTO-1:0] p, input logic [AW-1:0] ra, input string tag);
        cyc(p, '0, 0, '0, '0, 1, ra, tag);
    endtask

    // monitor
    always @(negedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check({it.tag, " enable"}, {{(DW-NP){1'b0}}, en}, {{(DW-NP){1'b0}}, it.en_exp});
            if (it.rd_chk) check({it.tag, " read"}, rd_data, it.rd_exp);
        end
    end

    initial begin
        #800000;
        if (!done) begin
            errs++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NP; i++) tail[i] = 0;
        rst_n = 0; wr_en = 0; rd_en = 0; wr_addr = '0; rd_addr = '0; wr_data = '0;
        pen = '0; acc = '0;
        repeat (3) @(negedge clk);
        #1 check("R7 reset read data", rd_data, '0);
        check("R7 reset enables", {{(DW-NP){1'b0}}, en}, {{(DW-NP){1'b0}}, 7'b1110000});
        @(negedge clk); rst_n = 1;

        rd(4'b0000, 2'd0, "R7 ctrl after reset");
        idle(4'b0000, "R7 ctrl readback");
        idle(4'b1010, "R1 pattern a");
        idle(4'b0101, "R1 pattern b");
        idle(4'b1111, "R1 all on");
        wr(4'b1111, 2'd0, 32'h0000_0005, "R2 write manual off");
        idle(4'b1111, "R2 mixed manual");
        rd(4'b0011, 2'd0, "R8 ctrl read");
        rd(4'b0011, 2'd1, "R8 status read");
        idle(4'b0011, "R8 status result");
        cyc(4'b0011, 7'b0010000, 0, '0, '0, 0, '0, "R4 access gated manual");
        idle(4'b0011, "R5 tail 1");
        idle(4'b0011, "R5 tail 2");
        idle(4'b0011, "R5 tail end");
        wr(4'b1111, 2'd0, 32'h8000_0000, "R3 master write");
        idle(4'b1111, "R3 master off");
        rd(4'b1111, 2'd1, "R8 status under master");
        cyc(4'b1111, 7'b0000010, 0, '0, '0, 0, '0, "R4 access under master");
        idle(4'b1111, "R5 master tail 1");
        idle(4'b1111, "R5 master tail 2");
        idle(4'b1111, "R5 master tail end");
        cyc(4'b0000, 7'b1000001, 0, '0, '0, 0, '0, "R4 two accesses");
        idle(4'b0000, "R5 restart gap");
        cyc(4'b0000, 7'b1000000, 0, '0, '0, 0, '0, "R5 restart access");
        idle(4'b0000, "R5 restart tail 1");
        idle(4'b0000, "R5 restart tail 2");
        idle(4'b0000, "R5 restart end");
        wr(4'b0000, 2'd1, 32'hFFFF_FFFF, "R9 write status addr");
        rd(4'b0000, 2'd0, "R9 ctrl unchanged");
        rd(4'b0000, 2'd2, "R9 after write");
        idle(4'b0000, "R8 unused addr");
        wr(4'b0001, 2'd3, 32'h0000_0000, "R9 write unused addr");
        wr(4'b0001, 2'd0, 32'h0000_0002, "R3 master clear");
        rd(4'b0001, 2'd0, "R3 ctrl after clear");
        idle(4'b0001, "R3 clocks back");
        idle(4'b0001, "R1 steady");

        @(negedge clk);
        #2;
        // R6: change during high phase is not visible until after falling edge
        @(posedge clk); #1;
        pen[0] = 1'b0;
        #0.5 check("R6 high phase hold", {{(DW-1){1'b0}}, en[0]}, 32'd1);
        @(negedge clk); #1;
        check("R6 after fall", {{(DW-1){1'b0}}, en[0]}, 32'd0);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule